// File: doc/BRIEF.md
# Sequential Radix-4 Booth Integer Multiplier

This block multiplies two unsigned integers of `W` bits each (256 by default) and returns the complete `2W`-bit product. It works iteratively and handles two multiplier bits on every clock. The multiplier operand sits in the low half of a shifting register, with an accumulator above it. On each step, a three-bit window at the bottom of that register selects one of five actions: add nothing, add the multiplicand, add twice it, subtract it, or subtract twice it. The register then shifts right arithmetically by two places.

A caller drives both operands and raises `start` while the block is idle. The block captures the operands on that edge and raises `busy`. After `W/2` steps it drops `busy`, pulses `done` for one cycle, and presents the product. The product then stays unchanged until the next run completes. Because Booth recoding treats its input as signed, the top multiplier bit is corrected in the last step. That step also adds four times the multiplicand when the top multiplier bit is set, so the run is no longer than `W/2` cycles. Modular reduction is left to a later stage.

Top module: `booth_mul`

## Requirements
- R1: While reset is asserted and right after it, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` seen high at a rising edge while idle captures `multiplier` and `multiplicand`, and `busy` is 1 from that edge on.
- R3: `busy` stays high for exactly `W/2` cycles (128 for the default width), and `done` rises on the edge where `busy` falls.
- R4: When `done` is 1, `product` equals the exact unsigned product of the captured operands, for any operand values including 0, 1 and all-ones.
- R5: `done` is high for exactly one cycle per run, and `busy` is 0 while `done` is 1.
- R6: While `busy` is 1, changes on `start`, `multiplier` and `multiplicand` have no effect on the running product or on the cycle in which it completes.
- R7: `product` keeps its value from one completion until the next, whatever the operand inputs do in between.
- R8: A multiplier with its most significant bit set is treated as a large unsigned value, not as a negative one, so the result for a multiplier of all-ones or of 2^(W-1) is the exact unsigned product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiplication while idle |
| multiplier | input | W | Unsigned multiplier operand |
| multiplicand | input | W | Unsigned multiplicand operand |
| busy | output | 1 | High while the iteration runs |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | 2W | Full unsigned product of the last completed run |

## Verification
A 6-bit copy of the block is swept through all 4096 operand pairs. This sweep reaches every Booth window on every step, including the final-step correction for the top multiplier bit, and it tells an exact unsigned product apart from a signed one or from a product that is off by one recoding digit. The full 256-bit width is run with zeros, ones, all-ones, a lone top bit, alternating bits and random words. These show that the carries across the wide accumulator and the final correction are right at size. Some of those runs also change the operands and pulse `start` during the iteration, or change the operands after completion, to show that nothing leaks into the running or the held result.

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     multiplier,
  input  logic [W-1:0]     multiplicand,
  output logic             busy,
  output logic             done,
  output logic [2*W-1:0]   product
);

  localparam int STEPS = W / 2;
  localparam int CW    = $clog2(STEPS);
  localparam int AW    = W + 4;

  typedef enum logic {IDLE, BUSY} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   acc;
  logic [W-1:0]    mq;
  logic            qm1;
  logic [W-1:0]    mcand;
  logic [2*W-1:0]  res;
  logic            done_q;

  logic [2:0]      window;
  logic [AW-1:0]   m_ext, pp, corr, sum, acc_nx;
  logic [W-1:0]    mq_nx;
  logic            last;

  assign last   = (cnt == CW'(STEPS - 1));
  assign window = {mq[1:0], qm1};
  assign m_ext  = {4'b0000, mcand};

  always_comb begin
    unique case (window)
      3'b001, 3'b010: pp = m_ext;
      3'b011:         pp = m_ext << 1;
      3'b100:         pp = -(m_ext << 1);
      3'b101, 3'b110: pp = -m_ext;
      default:        pp = '0;
    endcase
  end

  // top multiplier bit is unsigned weight: fold +4M into the last step
  assign corr   = (last && mq[1]) ? (m_ext << 2) : '0;
  assign sum    = acc + pp + corr;
  assign acc_nx = AW'($signed(sum) >>> 2);
  assign mq_nx  = {sum[1:0], mq[W-1:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      cnt    <= '0;
      acc    <= '0;
      mq     <= '0;
      qm1    <= 1'b0;
      mcand  <= '0;
      res    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        IDLE: if (start) begin
          mq    <= multiplier;
          mcand <= multiplicand;
          acc   <= '0;
          qm1   <= 1'b0;
          cnt   <= '0;
          state <= BUSY;
        end
        BUSY: begin
          acc <= acc_nx;
          mq  <= mq_nx;
          qm1 <= mq[1];
          cnt <= cnt + 1'b1;
          if (last) begin
            res    <= {acc_nx[W-1:0], mq_nx};
            done_q <= 1'b1;
            state  <= IDLE;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy    = (state == BUSY);
  assign done    = done_q;
  assign product = res;

endmodule

module booth_mul_chk #(
  parameter int W = 256
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);

  localparam int STEPS = W / 2;

  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 16'd1;
    else           run_len <= '0;
  end

  AST_START_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);                // R2
  AST_RUN_LENGTH:  assert property (@(posedge clk) disable iff (!rst_n) done |-> (run_len == 16'(STEPS)));        // R3
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                          // R5
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);                          // R5
  AST_BUSY_HOLDS:  assert property (@(posedge clk) disable iff (!rst_n) (busy && run_len < 16'(STEPS - 1)) |=> busy); // R6
  AST_PROD_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(product));              // R7

endmodule

bind booth_mul booth_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .product(product)
);

// File: tb/tb_booth_mul.sv
module tb_booth_mul;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 256;
  localparam int WS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic            start = 1'b0;
  logic [WB-1:0]   mplr = '0, mcnd = '0;
  logic            busy, done;
  logic [2*WB-1:0] prod;

  logic            s_start = 1'b0;
  logic [WS-1:0]   s_a = '0, s_b = '0;
  logic            s_busy, s_done;
  logic [2*WS-1:0] s_prod;

  booth_mul #(.W(WB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .multiplier(mplr), .multiplicand(mcnd),
    .busy(busy), .done(done), .product(prod));

  booth_mul #(.W(WS)) dut_small (
    .clk(clk), .rst_n(rst_n), .start(s_start), .multiplier(s_a), .multiplicand(s_b),
    .busy(s_busy), .done(s_done), .product(s_prod));

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WB-1:0] rnd_word();
    logic [WB-1:0] v;
    for (int i = 0; i < WB/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_big(input logic [WB-1:0] a, input logic [WB-1:0] b, input string tag, input bit poke);
    logic [511:0] exp;
    int n;
    exp = {256'b0, a} * {256'b0, b};
    @(negedge clk); start = 1'b1; mplr = a; mcnd = b;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 512'(busy), 512'd1);
    n = 0;
    while (!done && n < WB/2 + 20) begin
      @(negedge clk); n++;
      if (poke && n == 5) begin start = 1'b1; mplr = ~a; mcnd = b ^ {WB{1'b1}}; end
      else if (poke && n == 6) start = 1'b0;
    end
    chk(n == WB/2, poke ? "R6 completion cycle" : "R3 latency", 512'(n), 512'(WB/2));
    chk(prod == exp, tag, prod, exp);
    chk(busy == 1'b0, "R5 busy low at done", 512'(busy), 512'd0);
    @(negedge clk);
    chk(done == 1'b0, "R5 done one cycle", 512'(done), 512'd0);
    mplr = rnd_word(); mcnd = rnd_word();
    repeat (3) @(negedge clk);
    chk(prod == exp, "R7 product held", prod, exp);
  endtask

  task automatic run_small(input logic [WS-1:0] a, input logic [WS-1:0] b);
    logic [2*WS-1:0] exp;
    int n;
    exp = 12'(a) * 12'(b);
    @(negedge clk); s_start = 1'b1; s_a = a; s_b = b;
    @(negedge clk); s_start = 1'b0;
    n = 0;
    while (!s_done && n < 20) begin @(negedge clk); n++; end
    chk(n == WS/2, "R3 small latency", 512'(n), 512'(WS/2));
    if (a[WS-1]) chk(s_prod == exp, "R8 small msb-set product", 512'(s_prod), 512'(exp));
    else         chk(s_prod == exp, "R4 small product", 512'(s_prod), 512'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && prod == '0, "R1 reset state", {busy, done, prod[509:0]}, 512'd0);
    chk(s_busy == 0 && s_done == 0 && s_prod == '0, "R1 small reset state", 512'({s_busy, s_done, s_prod}), 512'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && prod == '0, "R1 after reset", {busy, done, prod[509:0]}, 512'd0);

    for (int a = 0; a < (1 << WS); a++)
      for (int b = 0; b < (1 << WS); b++)
        run_small(WS'(a), WS'(b));

    run_big('0, rnd_word(), "R4 zero multiplier", 1'b0);
    run_big(rnd_word(), '0, "R4 zero multiplicand", 1'b0);
    run_big(256'd1, rnd_word(), "R4 one multiplier", 1'b0);
    run_big(rnd_word(), 256'd1, "R4 one multiplicand", 1'b0);
    run_big({WB{1'b1}}, {WB{1'b1}}, "R8 all-ones both", 1'b0);
    run_big({WB{1'b1}}, 256'd1, "R8 all-ones multiplier", 1'b0);
    run_big(256'd1 << (WB-1), {WB{1'b1}}, "R8 top bit only", 1'b0);
    run_big({(WB/2){2'b10}}, {(WB/2){2'b01}}, "R4 alternating bits", 1'b0);
    run_big(rnd_word(), rnd_word(), "R6 operands changed while busy", 1'b1);
    for (int i = 0; i < 12; i++) run_big(rnd_word(), rnd_word(), "R4 random", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule